// File: doc/BRIEF.md
# System Control Register File

This block holds the privileged control registers of a processor core. Registers are addressed by a 5-bit register number and a 3-bit select, through one write port that updates on the clock edge and one read port whose data follows the address combinationally. Every register has its own set of writable bits. Some registers also have bits that a write keeps at their stored value, and bits that a write forces to zero.

Two side outputs follow from writes. A write that changes the 8-bit address-space identifier held in the low byte of the translation-tag register produces a one-cycle flush pulse. A write that turns on the global interrupt enable while interrupt causes are already pending and unmasked raises an interrupt request, and the request stays up until a later write turns the enable off. A load-linked address is captured from a separate strobe and read back in a compressed form. Timer behaviour, translation-table operations and exception entry are handled elsewhere. Here the timer registers are plain storage.

Top module: `sysctl_regfile`

## Requirements
- R1: A write with a nonzero select changes no register. A write to a number with no storage (1, 7, 8, 15, 17, 20-22, 25-27, 29) also changes nothing. Reads of such addresses return zero. The two exceptions are number 16 select 1, which reads the constant parameter CFG1_VALUE, and number 15 select 0, which reads PRID_VALUE.
- R2: A write to register 0 (slot index) stores write-data bits 3:0 and keeps stored bit 31. All other bits stay zero.
- R3: The translation registers take only the write-data bits under their masks: registers 2 and 3 use 0x3FFFFFFF, register 5 uses 0x01FFE000, register 6 uses 0x0000000F and register 10 uses 0xFFFFE0FF.
- R4: Register 12 (status) takes write data under 0xFA78FF01. Register 19 takes write data under 0x40FF0FF8. Register 28 select 0 takes write data under 0xFFFFFCF6.
- R5: The following registers keep their stored bits under one mask and take write data under a second mask. Register 4 keeps 0xFF800000 and takes 0x007FFFF0. Register 23 keeps 0x8C03FC1F and takes 0x13300120. Register 13 (cause) keeps 0xB000F87C and takes 0x00C00300. Register 16 select 0 keeps 0xFE17FF80 and takes bit 0.
- R6: Registers 9, 11, 14, 18, 24, 30 and 31 store all 32 write-data bits.
- R7: flush_pulse is high for exactly the one cycle after a write to register 10 select 0 that changes stored bits 7:0. It stays low when those bits are unchanged.
- R8: irq_req rises after a status write that meets all of these conditions: it sets bit 0 (enable) where the bit was clear; write-data bits 1 and 2 (exception and error level) are clear; dbg_mode is low; and (new status AND cause AND 0x0000FF00) is nonzero. A later write that sets the enable again holds the request, and so does a change to cause.
- R9: irq_req falls after a status write that clears bit 0 where the bit was set.
- R10: ll_load captures ll_addr. Register 17 then reads the captured address shifted right by 4.
- R11: After reset, every stored register reads zero, register 16 select 0 reads CFG0_INIT, and flush_pulse and irq_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_num | input | 5 | Register number to write |
| wr_sel | input | 3 | Select to write |
| wr_data | input | 32 | Write data |
| rd_num | input | 5 | Register number to read |
| rd_sel | input | 3 | Select to read |
| rd_data | output | 32 | Read data (combinational) |
| dbg_mode | input | 1 | Core is in debug mode |
| ll_load | input | 1 | Capture strobe for the load-linked address |
| ll_addr | input | 32 | Load-linked address |
| flush_pulse | output | 1 | Translation flush, one cycle |
| irq_req | output | 1 | Interrupt-raise request (level) |

## Verification
A table writes every implemented register with all-ones, or with a mixed pattern, and reads it back. All-ones shows the exact writable mask. A mixed pattern shows whether bits are kept or passed through. Invalid-select writes are followed by reads of the select-0 register that a wrong decode would have overwritten. The interrupt request is driven through status writes that each leave out exactly one of the raise conditions, so every missing term must on its own keep the request down. Repeated writes show the hold and withdraw behaviour. For the flush, writes to the tag register are applied with an identical identifier, with only the upper bits changed, with a new identifier, and at an invalid select.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int NUM_W = 5;
  localparam int SEL_W = 3;
  localparam int XLEN  = 32;
  localparam int ASID_W = 8;
  localparam int LL_SHIFT = 4;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [4:0] {
    SL_SLOT, SL_MAPLO0, SL_MAPLO1, SL_CTX, SL_PGMASK, SL_PINNED, SL_TICK,
    SL_MAPHI, SL_TICKCMP, SL_STAT, SL_CAUSE, SL_EXCPC, SL_CFG0, SL_WPLO,
    SL_WPHI, SL_DBG, SL_DBGPC, SL_CTAG, SL_ERRPC, SL_DSCRATCH, SL_NONE
  } slot_e;

  localparam int NSLOT = int'(SL_NONE);

  localparam logic [NUM_W-1:0] RN_MAPHI = 5'd10;
  localparam logic [NUM_W-1:0] RN_STAT  = 5'd12;
  localparam logic [NUM_W-1:0] RN_IDENT = 5'd15;
  localparam logic [NUM_W-1:0] RN_CFG   = 5'd16;
  localparam logic [NUM_W-1:0] RN_LINK  = 5'd17;

  localparam word_t IP_MASK = 32'h0000_FF00;
  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;

  function automatic slot_e slot_of(logic [NUM_W-1:0] num, logic [SEL_W-1:0] sel);
    slot_e s;
    s = SL_NONE;
    if (sel == '0) begin
      case (num)
        5'd0:  s = SL_SLOT;
        5'd2:  s = SL_MAPLO0;
        5'd3:  s = SL_MAPLO1;
        5'd4:  s = SL_CTX;
        5'd5:  s = SL_PGMASK;
        5'd6:  s = SL_PINNED;
        5'd9:  s = SL_TICK;
        5'd10: s = SL_MAPHI;
        5'd11: s = SL_TICKCMP;
        5'd12: s = SL_STAT;
        5'd13: s = SL_CAUSE;
        5'd14: s = SL_EXCPC;
        5'd16: s = SL_CFG0;
        5'd18: s = SL_WPLO;
        5'd19: s = SL_WPHI;
        5'd23: s = SL_DBG;
        5'd24: s = SL_DBGPC;
        5'd28: s = SL_CTAG;
        5'd30: s = SL_ERRPC;
        5'd31: s = SL_DSCRATCH;
        default: s = SL_NONE;
      endcase
    end
    return s;
  endfunction

  function automatic word_t keep_mask(slot_e s);
    case (s)
      SL_SLOT:  return 32'h8000_0000;
      SL_CTX:   return 32'hFF80_0000;
      SL_CAUSE: return 32'hB000_F87C;
      SL_CFG0:  return 32'hFE17_FF80;
      SL_DBG:   return 32'h8C03_FC1F;
      default:  return 32'h0000_0000;
    endcase
  endfunction

  function automatic word_t take_mask(slot_e s);
    case (s)
      SL_SLOT:   return 32'h0000_000F;
      SL_MAPLO0: return 32'h3FFF_FFFF;
      SL_MAPLO1: return 32'h3FFF_FFFF;
      SL_CTX:    return 32'h007F_FFF0;
      SL_PGMASK: return 32'h01FF_E000;
      SL_PINNED: return 32'h0000_000F;
      SL_MAPHI:  return 32'hFFFF_E0FF;
      SL_STAT:   return 32'hFA78_FF01;
      SL_CAUSE:  return 32'h00C0_0300;
      SL_CFG0:   return 32'h0000_0001;
      SL_WPHI:   return 32'h40FF_0FF8;
      SL_DBG:    return 32'h1330_0120;
      SL_CTAG:   return 32'hFFFF_FCF6;
      SL_NONE:   return 32'h0000_0000;
      default:   return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic word_t merge(word_t old, word_t wd, word_t keep, word_t take);
    return (old & keep) | (wd & take);
  endfunction

  function automatic logic asid_moved(word_t old, word_t nxt);
    return old[ASID_W-1:0] != nxt[ASID_W-1:0];
  endfunction

  function automatic logic may_raise(word_t old, word_t wd, word_t nxt,
                                     word_t cause, logic dbg);
    return nxt[ST_IE] && !old[ST_IE] && !wd[ST_EXL] && !wd[ST_ERL] && !dbg
           && ((nxt & cause & IP_MASK) != '0);
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [NUM_W-1:0] num,
  input  logic [SEL_W-1:0] sel,
  output slot_e            slot,
  output logic             hit,
  output logic [NSLOT-1:0] onehot
);
  assign slot = slot_of(num, sel);
  assign hit  = (slot != SL_NONE);

  for (genvar i = 0; i < NSLOT; i++) begin : g_oh
    assign onehot[i] = (slot == slot_e'(i));
  end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter word_t CFG0_INIT = 32'h8000_8080
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSLOT-1:0]           wr_onehot,
  input  word_t                      wr_data,
  output logic [NSLOT-1:0][XLEN-1:0] q
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_reg
    localparam slot_e SL   = slot_e'(i);
    localparam word_t KEEP = keep_mask(SL);
    localparam word_t TAKE = take_mask(SL);
    localparam word_t INIT = (SL == SL_CFG0) ? CFG0_INIT : '0;

    always_ff @(posedge clk) begin
      if (!rst_n)            q[i] <= INIT;
      else if (wr_onehot[i]) q[i] <= merge(q[i], wr_data, KEEP, TAKE);
    end
  end
endmodule

// File: rtl/sysctl_events.sv
module sysctl_events
  import sysctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stat_wr,
  input  word_t stat_old,
  input  word_t stat_wdata,
  input  word_t stat_new,
  input  word_t cause_q,
  input  logic  dbg_mode,
  input  logic  maphi_wr,
  input  word_t maphi_old,
  input  word_t maphi_new,
  output logic  raise_ev,
  output logic  drop_ev,
  output logic  flush_ev,
  output logic  flush_pulse,
  output logic  irq_req
);
  assign raise_ev = stat_wr && may_raise(stat_old, stat_wdata, stat_new, cause_q, dbg_mode);
  assign drop_ev  = stat_wr && stat_old[ST_IE] && !stat_new[ST_IE];
  assign flush_ev = maphi_wr && asid_moved(maphi_old, maphi_new);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_pulse <= 1'b0;
      irq_req     <= 1'b0;
    end else begin
      flush_pulse <= flush_ev;
      if (raise_ev)     irq_req <= 1'b1;
      else if (drop_ev) irq_req <= 1'b0;
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [31:0] CFG0_INIT  = 32'h8000_8080,
  parameter logic [31:0] CFG1_VALUE = 32'h9E19_0C8A,
  parameter logic [31:0] PRID_VALUE = 32'h0001_8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_num,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_num,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        dbg_mode,
  input  logic        ll_load,
  input  logic [31:0] ll_addr,
  output logic        flush_pulse,
  output logic        irq_req
);
  slot_e                      wr_slot, rd_slot;
  logic                       wr_dec_hit, rd_hit, wr_hit;
  logic [NSLOT-1:0]           wr_dec_oh, rd_oh, wr_onehot;
  logic [NSLOT-1:0][XLEN-1:0] bank_q;
  word_t                      ll_q;
  word_t                      stat_q, cause_q, maphi_q, slot_q;
  word_t                      stat_new, maphi_new;
  logic                       stat_wr, maphi_wr;
  logic                       raise_ev, drop_ev, flush_ev;

  sysctl_decode u_wdec (.num(wr_num), .sel(wr_sel), .slot(wr_slot),
                        .hit(wr_dec_hit), .onehot(wr_dec_oh));
  sysctl_decode u_rdec (.num(rd_num), .sel(rd_sel), .slot(rd_slot),
                        .hit(rd_hit), .onehot(rd_oh));

  assign wr_hit    = wr_en && wr_dec_hit;
  assign wr_onehot = wr_en ? wr_dec_oh : '0;

  sysctl_bank #(.CFG0_INIT(CFG0_INIT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_onehot(wr_onehot), .wr_data(wr_data), .q(bank_q)
  );

  assign stat_q  = bank_q[SL_STAT];
  assign cause_q = bank_q[SL_CAUSE];
  assign maphi_q = bank_q[SL_MAPHI];
  assign slot_q  = bank_q[SL_SLOT];

  assign stat_wr   = wr_onehot[SL_STAT];
  assign maphi_wr  = wr_onehot[SL_MAPHI];
  assign stat_new  = merge(stat_q, wr_data, keep_mask(SL_STAT), take_mask(SL_STAT));
  assign maphi_new = merge(maphi_q, wr_data, keep_mask(SL_MAPHI), take_mask(SL_MAPHI));

  sysctl_events u_evt (
    .clk(clk), .rst_n(rst_n),
    .stat_wr(stat_wr), .stat_old(stat_q), .stat_wdata(wr_data), .stat_new(stat_new),
    .cause_q(cause_q), .dbg_mode(dbg_mode),
    .maphi_wr(maphi_wr), .maphi_old(maphi_q), .maphi_new(maphi_new),
    .raise_ev(raise_ev), .drop_ev(drop_ev), .flush_ev(flush_ev),
    .flush_pulse(flush_pulse), .irq_req(irq_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ll_q <= '0;
    else if (ll_load) ll_q <= ll_addr;
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      for (int i = 0; i < NSLOT; i++)
        if (rd_oh[i]) rd_data = bank_q[i];
    end else if (rd_num == RN_IDENT && rd_sel == 3'd0) begin
      rd_data = PRID_VALUE;
    end else if (rd_num == RN_LINK && rd_sel == 3'd0) begin
      rd_data = ll_q >> LL_SHIFT;
    end else if (rd_num == RN_CFG && rd_sel == 3'd1) begin
      rd_data = CFG1_VALUE;
    end
  end
endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  wr_num,
  input logic [2:0]  wr_sel,
  input logic        wr_hit,
  input logic [31:0] slot_q,
  input logic [31:0] stat_q,
  input logic [31:0] maphi_q,
  input logic        flush_pulse,
  input logic        irq_req
);
  AST_BAD_SEL_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != 3'd0) |-> !wr_hit); // R1

  AST_SLOT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q[31:4] == 28'd0); // R2

  AST_STAT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~32'hFA78_FF01) == 32'd0); // R4

  AST_FLUSH_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> ($past(wr_en) && $past(wr_num) == 5'd10 && $past(wr_sel) == 3'd0
                     && $past(maphi_q[7:0]) != maphi_q[7:0])); // R7

  AST_IRQ_RISE_ON_IE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> (stat_q[0] && !$past(stat_q[0]))); // R8

  AST_IRQ_FALL_ON_IE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_req) |-> (!stat_q[0] && $past(stat_q[0]))); // R9
endmodule

bind sysctl_regfile sysctl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num), .wr_sel(wr_sel),
  .wr_hit(wr_hit), .slot_q(slot_q), .stat_q(stat_q), .maphi_q(maphi_q),
  .flush_pulse(flush_pulse), .irq_req(irq_req)
);

// File: tb/tb_sysctl_regfile.sv
module tb_sysctl_regfile;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CFG0 = 32'h8000_8080;
  localparam logic [31:0] CFG1 = 32'h9E19_0C8A;
  localparam logic [31:0] PRID = 32'h0001_8000;

  typedef struct packed {
    logic [7:0]  req;
    logic [4:0]  n;
    logic [2:0]  s;
    logic [31:0] w;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  5'd0,  3'd0, 32'hFFFFFFFF, 32'h0000000F},  // R2
    '{8'd3,  5'd2,  3'd0, 32'hFFFFFFFF, 32'h3FFFFFFF},  // R3
    '{8'd3,  5'd3,  3'd0, 32'hC0000001, 32'h00000001},  // R3
    '{8'd5,  5'd4,  3'd0, 32'hFFFFFFFF, 32'h007FFFF0},  // R5
    '{8'd3,  5'd5,  3'd0, 32'hFFFFFFFF, 32'h01FFE000},  // R3
    '{8'd3,  5'd6,  3'd0, 32'h12345678, 32'h00000008},  // R3
    '{8'd6,  5'd9,  3'd0, 32'hDEADBEEF, 32'hDEADBEEF},  // R6
    '{8'd3,  5'd10, 3'd0, 32'hFFFFFFFF, 32'hFFFFE0FF},  // R3
    '{8'd6,  5'd11, 3'd0, 32'hCAFEF00D, 32'hCAFEF00D},  // R6
    '{8'd4,  5'd12, 3'd0, 32'hFFFFFFFF, 32'hFA78FF01},  // R4
    '{8'd5,  5'd13, 3'd0, 32'hFFFFFFFF, 32'h00C00300},  // R5
    '{8'd6,  5'd14, 3'd0, 32'h12345678, 32'h12345678},  // R6
    '{8'd5,  5'd16, 3'd0, 32'hFFFFFFFF, 32'h80008081},  // R5
    '{8'd5,  5'd16, 3'd0, 32'h00000000, 32'h80008080},  // R5
    '{8'd6,  5'd18, 3'd0, 32'hA5A5A5A5, 32'hA5A5A5A5},  // R6
    '{8'd4,  5'd19, 3'd0, 32'hFFFFFFFF, 32'h40FF0FF8},  // R4
    '{8'd5,  5'd23, 3'd0, 32'hFFFFFFFF, 32'h13300120},  // R5
    '{8'd6,  5'd24, 3'd0, 32'h11111111, 32'h11111111},  // R6
    '{8'd4,  5'd28, 3'd0, 32'hFFFFFFFF, 32'hFFFFFCF6},  // R4
    '{8'd6,  5'd30, 3'd0, 32'h87654321, 32'h87654321},  // R6
    '{8'd6,  5'd31, 3'd0, 32'h0F0F0F0F, 32'h0F0F0F0F},  // R6
    '{8'd1,  5'd7,  3'd0, 32'hFFFFFFFF, 32'h00000000},  // R1
    '{8'd1,  5'd2,  3'd1, 32'h00000000, 32'h00000000}   // R1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_num = '0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_num = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        dbg_mode = 1'b0;
  logic        ll_load = 1'b0;
  logic [31:0] ll_addr = '0;
  logic        flush_pulse, irq_req;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regfile #(.CFG0_INIT(CFG0), .CFG1_VALUE(CFG1), .PRID_VALUE(PRID)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_num(rd_num), .rd_sel(rd_sel), .rd_data(rd_data),
    .dbg_mode(dbg_mode), .ll_load(ll_load), .ll_addr(ll_addr),
    .flush_pulse(flush_pulse), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp_v);
    end
  endtask

  task automatic wr(input logic [4:0] n, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_num = n; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] n, input logic [2:0] s, output logic [31:0] d);
    rd_num = n; rd_sel = s;
    #1;
    d = rd_data;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rd(5'd0, 3'd0, v);  chk("R11 slot reset", v, 32'h0);
    rd(5'd12, 3'd0, v); chk("R11 status reset", v, 32'h0);
    rd(5'd10, 3'd0, v); chk("R11 tag reset", v, 32'h0);
    rd(5'd16, 3'd0, v); chk("R11 cfg0 reset", v, CFG0);
    chk("R11 flush reset", {31'd0, flush_pulse}, 32'd0);
    chk("R11 irq reset", {31'd0, irq_req}, 32'd0);
    rd(5'd16, 3'd1, v); chk("R1 cfg1 constant", v, CFG1);
    rd(5'd15, 3'd0, v); chk("R1 ident constant", v, PRID);
    rd(5'd28, 3'd1, v); chk("R1 invalid sel read", v, 32'h0);
    rd(5'd16, 3'd2, v); chk("R1 invalid cfg sel read", v, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].n, VECS[i].s, VECS[i].w);
      rd(VECS[i].n, VECS[i].s, v);
      checks++;
      if (v !== VECS[i].e) begin
        errors++;
        $display("FAIL R%0d reg %0d sel %0d: actual %08h expected %08h",
                 VECS[i].req, VECS[i].n, VECS[i].s, v, VECS[i].e);
      end
    end
    rd(5'd2, 3'd0, v); chk("R1 sel1 write left reg2", v, 32'h3FFFFFFF);
    wr(5'd12, 3'd3, 32'h0); rd(5'd12, 3'd0, v); chk("R1 sel3 write left status", v, 32'hFA78FF01);
    wr(5'd0, 3'd0, 32'h80000005); rd(5'd0, 3'd0, v); chk("R2 bit31 kept", v, 32'h00000005);

    // Flush pulse
    wr(5'd10, 3'd0, 32'hFFFFE0FF); chk("R7 same id no flush", {31'd0, flush_pulse}, 32'd0);
    wr(5'd10, 3'd0, 32'h000000FF); chk("R7 upper change no flush", {31'd0, flush_pulse}, 32'd0);
    wr(5'd10, 3'd0, 32'h00000012); chk("R7 id change flush", {31'd0, flush_pulse}, 32'd1);
    @(negedge clk); chk("R7 flush one cycle", {31'd0, flush_pulse}, 32'd0);
    wr(5'd10, 3'd1, 32'h00000034); chk("R7 invalid sel no flush", {31'd0, flush_pulse}, 32'd0);
    rd(5'd10, 3'd0, v); chk("R1 tag after invalid", v, 32'h00000012);

    // Interrupt request
    wr(5'd12, 3'd0, 32'h0);
    wr(5'd13, 3'd0, 32'h0);
    wr(5'd12, 3'd0, 32'h0000FF01); chk("R8 no pending no raise", {31'd0, irq_req}, 32'd0);
    wr(5'd12, 3'd0, 32'h0000FF00);
    wr(5'd13, 3'd0, 32'h00000100);
    dbg_mode = 1'b1;
    wr(5'd12, 3'd0, 32'h0000FF01); chk("R8 debug blocks", {31'd0, irq_req}, 32'd0);
    dbg_mode = 1'b0;
    wr(5'd12, 3'd0, 32'h0000FF00);
    wr(5'd12, 3'd0, 32'h0000FF03); chk("R8 exl blocks", {31'd0, irq_req}, 32'd0);
    wr(5'd12, 3'd0, 32'h0000FF00);
    wr(5'd12, 3'd0, 32'h0000FF05); chk("R8 erl blocks", {31'd0, irq_req}, 32'd0);
    wr(5'd12, 3'd0, 32'h0000FF00);
    wr(5'd12, 3'd0, 32'h0000FE01); chk("R8 masked cause", {31'd0, irq_req}, 32'd0);
    wr(5'd12, 3'd0, 32'h0000FF00);
    wr(5'd12, 3'd0, 32'h0000FF01); chk("R8 raise", {31'd0, irq_req}, 32'd1);
    wr(5'd12, 3'd0, 32'h0000FF01); chk("R8 hold on rewrite", {31'd0, irq_req}, 32'd1);
    wr(5'd13, 3'd0, 32'h0);        chk("R8 hold on cause clear", {31'd0, irq_req}, 32'd1);
    wr(5'd12, 3'd0, 32'h0000FF00); chk("R9 withdraw", {31'd0, irq_req}, 32'd0);

    // Load-linked address
    @(negedge clk); ll_load = 1'b1; ll_addr = 32'h12345678;
    @(negedge clk); ll_load = 1'b0; ll_addr = 32'hFFFFFFFF;
    rd(5'd17, 3'd0, v); chk("R10 shifted read", v, 32'h01234567);
    wr(5'd17, 3'd0, 32'h0); rd(5'd17, 3'd0, v); chk("R10 write ignored", v, 32'h01234567);

    // Reset in mid-run
    wr(5'd12, 3'd0, 32'h0000FF01);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(5'd12, 3'd0, v); chk("R11 status after reset", v, 32'h0);
    chk("R11 irq after reset", {31'd0, irq_req}, 32'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule